// File: doc/BRIEF.md
# Packet-Commit Write Controller for a Synchronous Slave FIFO

This block is the master side of a synchronous slave FIFO write port. It takes a word stream from an upstream valid/ready source. It drives a write strobe, a data word and an endpoint address toward a peripheral's IN endpoint, all on the shared interface clock. Every output toward the FIFO comes from a register.

Packets reach the host in two ways. A full packet is committed when the running byte count reaches a programmable auto-commit length. A short packet is committed when the upstream marks a word as the last one, which makes the block raise a packet-end strobe together with that word's write. The peripheral drops a short packet whose packet-end comes in the cycle right after the final write of an auto-committed packet. The controller stops this from happening: it holds back such a word for one cycle, and it delays a zero-length commit by the same gap.

The endpoint address is taken only between packets, so it never changes during a write or a packet-end strobe.

Top module: `pkt_commit_writer`

## Requirements
- R1: A word accepted on the upstream handshake (`in_valid` and `in_ready` high at a rising edge) appears on `fifo_data` with `fifo_wr` high in the following cycle. Each accepted word gives exactly one write cycle, and words leave in the order they arrived.
- R2: Each accepted word adds BUS_W/8 bytes to the running count (2 with the default 16-bit bus). A word that brings the count to `auto_len` or beyond completes an automatic packet. `pkt_auto` is high in the same cycle as that word's write, and the count returns to zero.
- R3: A word accepted with `in_last` high that does not complete an automatic packet is written with `fifo_pktend` high in the same cycle as its write. The count returns to zero, so the next automatic packet again needs `auto_len` bytes.
- R4: `fifo_pktend` is never high in the cycle right after a cycle with `pkt_auto` high. A word with `in_last` high that is offered while `pkt_auto` is high sees `in_ready` low for exactly that one cycle. It is taken in the next cycle, so its write and packet-end come out two cycles after the auto-completing write, with an idle cycle between them.
- R5: When a word with `in_last` high itself completes an automatic packet, no packet-end is issued if `zlp_en` is low. If `zlp_en` is high, a lone packet-end (with `fifo_wr` low) comes out two cycles after that word's write. `in_ready` is low in the word's output cycle and in the cycle after it, and is high again in the cycle of the lone packet-end. Packet-end is never raised on a zero count in any other case.
- R6: `in_ready` is low while `fifo_full` is high, and `fifo_wr` is low in every cycle that follows a cycle with `fifo_full` high.
- R7: `fifo_addr` takes the value of `ep_sel` one cycle later, but only when the count is zero, no word is being accepted and no strobe is being driven. While a packet is open it stays frozen, and it never changes in a cycle with `fifo_wr` or `fifo_pktend` high.
- R8: After reset `fifo_wr`, `fifo_pktend`, `pkt_auto` and `fifo_addr` are zero, the count is zero, and `in_ready` is high when `fifo_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | BUS_W | Upstream word |
| in_last | input | 1 | Commit the packet with this word |
| in_ready | output | 1 | Controller accepts the word this cycle |
| auto_len | input | LEN_W | Auto-commit length in bytes |
| zlp_en | input | 1 | Allow a zero-length commit after an auto packet |
| ep_sel | input | ADDR_W | Requested endpoint address |
| fifo_full | input | 1 | Endpoint full flag |
| fifo_wr | output | 1 | Write strobe toward the FIFO |
| fifo_data | output | BUS_W | Data toward the FIFO |
| fifo_pktend | output | 1 | Packet-end strobe |
| fifo_addr | output | ADDR_W | Endpoint address |
| pkt_auto | output | 1 | Current write completes an automatic packet |

## Verification
The bench targets the cycle right after an auto-completing write. A last word offered back to back there must see exactly one stall cycle, with nothing driven in that gap. A design without the guard would raise packet-end in that cycle, and the peripheral would silently drop the short packet. The bench also has a last word complete an auto packet, both with and without zero-length commits enabled. A design that got this wrong would send a stray empty packet, or would fire the lone packet-end too early. Further checks cover a full flag that holds a word back for several cycles, a count that must restart after a manual commit, and an address request made while a packet is open, which must not reach `fifo_addr` until the packet is committed.

// File: rtl/pcw_pkg.sv
`timescale 1ns/1ps
package pcw_pkg;
   // bytes carried by one bus word
   function automatic int unsigned bytes_per_word(input int unsigned bus_w);
      return bus_w / 8;
   endfunction
endpackage

// File: rtl/pcw_byte_count.sv
`timescale 1ns/1ps
module pcw_byte_count #(
   parameter int unsigned BUS_W = 16,
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             last,
   input  logic [LEN_W-1:0] auto_len,
   output logic             completes,
   output logic             cnt_zero
);
   localparam int unsigned STEP = pcw_pkg::bytes_per_word(BUS_W);
   localparam int unsigned CW   = LEN_W + 1;

   initial begin
      if (BUS_W != 8 && BUS_W != 16)
         $error("pcw_byte_count: BUS_W must be 8 or 16");
      if (LEN_W < 2)
         $error("pcw_byte_count: LEN_W too small");
   end

   logic [LEN_W-1:0] cnt_q;
   logic [CW-1:0]    cnt_next;

   generate
      if (STEP == 1) begin : g_byte_bus
         assign cnt_next = {1'b0, cnt_q} + CW'(1);
      end else begin : g_word_bus
         assign cnt_next = {1'b0, cnt_q} + CW'(2);
      end
   endgenerate

   assign completes = cnt_next >= {1'b0, auto_len};
   assign cnt_zero  = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (accept)
         cnt_q <= (completes || last) ? '0 : cnt_next[LEN_W-1:0];
   end

   AST_CNT_CLEARS_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (last || completes)) |=> cnt_zero); // R3
endmodule

// File: rtl/pcw_gap_guard.sv
`timescale 1ns/1ps
module pcw_gap_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic completes,
   input  logic in_valid,
   input  logic in_last,
   input  logic zlp_en,
   input  logic fifo_full,
   output logic in_ready,
   output logic zlp_fire,
   output logic zlp_pend,
   output logic auto_q
);
   // auto_q marks the cycle in which an auto-completing word is on the bus
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         auto_q   <= 1'b0;
         zlp_pend <= 1'b0;
      end else begin
         auto_q <= accept && completes;
         if (zlp_fire)
            zlp_pend <= 1'b0;
         else if (accept && completes && in_last && zlp_en)
            zlp_pend <= 1'b1;
      end
   end

   // a lone packet-end waits until the auto word's cycle has passed
   assign zlp_fire = zlp_pend && !auto_q;

   assign in_ready = !fifo_full && !zlp_pend && !(auto_q && in_valid && in_last);

   AST_STALL_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && completes && in_last && zlp_en) |=> !in_ready); // R5
endmodule

// File: rtl/pcw_out_stage.sv
`timescale 1ns/1ps
module pcw_out_stage #(
   parameter int unsigned BUS_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BUS_W-1:0]  in_data,
   input  logic              in_last,
   input  logic              completes,
   input  logic              zlp_fire,
   input  logic              zlp_pend,
   input  logic              cnt_zero,
   input  logic [ADDR_W-1:0] ep_sel,
   output logic              fifo_wr,
   output logic [BUS_W-1:0]  fifo_data,
   output logic              fifo_pktend,
   output logic [ADDR_W-1:0] fifo_addr
);
   logic addr_load;

   assign addr_load = cnt_zero && !zlp_pend && !accept && !fifo_wr && !fifo_pktend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_wr     <= 1'b0;
         fifo_data   <= '0;
         fifo_pktend <= 1'b0;
         fifo_addr   <= '0;
      end else begin
         fifo_wr     <= accept;
         fifo_pktend <= (accept && in_last && !completes) || zlp_fire;
         if (accept)
            fifo_data <= in_data;
         if (addr_load)
            fifo_addr <= ep_sel;
      end
   end

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr || fifo_pktend) |-> $stable(fifo_addr)); // R7
endmodule

// File: rtl/pkt_commit_writer.sv
`timescale 1ns/1ps
module pkt_commit_writer #(
   parameter int unsigned BUS_W  = 16,
   parameter int unsigned LEN_W  = 12,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BUS_W-1:0]  in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic [LEN_W-1:0]  auto_len,
   input  logic              zlp_en,
   input  logic [ADDR_W-1:0] ep_sel,
   input  logic              fifo_full,
   output logic              fifo_wr,
   output logic [BUS_W-1:0]  fifo_data,
   output logic              fifo_pktend,
   output logic [ADDR_W-1:0] fifo_addr,
   output logic              pkt_auto
);
   logic accept, completes, cnt_zero, zlp_fire, zlp_pend;

   assign accept = in_valid && in_ready;

   pcw_byte_count #(.BUS_W(BUS_W), .LEN_W(LEN_W)) u_count (
      .clk(clk), .rst_n(rst_n), .accept(accept), .last(in_last),
      .auto_len(auto_len), .completes(completes), .cnt_zero(cnt_zero)
   );

   pcw_gap_guard u_guard (
      .clk(clk), .rst_n(rst_n), .accept(accept), .completes(completes),
      .in_valid(in_valid), .in_last(in_last), .zlp_en(zlp_en),
      .fifo_full(fifo_full), .in_ready(in_ready), .zlp_fire(zlp_fire),
      .zlp_pend(zlp_pend), .auto_q(pkt_auto)
   );

   pcw_out_stage #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_out (
      .clk(clk), .rst_n(rst_n), .accept(accept), .in_data(in_data),
      .in_last(in_last), .completes(completes), .zlp_fire(zlp_fire),
      .zlp_pend(zlp_pend), .cnt_zero(cnt_zero), .ep_sel(ep_sel),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_pktend(fifo_pktend),
      .fifo_addr(fifo_addr)
   );

   AST_GAP_AFTER_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_auto |=> !fifo_pktend); // R4
   AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |=> !fifo_wr); // R6
   AST_ONE_WRITE_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> fifo_wr); // R1
endmodule

// File: tb/pkt_commit_writer_test.sv
`timescale 1ns/1ps
module pkt_commit_writer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic [11:0] auto_len = 12'd8;
   logic        zlp_en = 1'b0;
   logic [1:0]  ep_sel = '0;
   logic        fifo_full = 1'b0;
   logic        fifo_wr, fifo_pktend, pkt_auto;
   logic [15:0] fifo_data;
   logic [1:0]  fifo_addr;

   int n_checks = 0;
   int n_fail   = 0;
   int gap_hits = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pkt_commit_writer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .auto_len(auto_len),
      .zlp_en(zlp_en), .ep_sel(ep_sel), .fifo_full(fifo_full),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_pktend(fifo_pktend),
      .fifo_addr(fifo_addr), .pkt_auto(pkt_auto)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // offer one word; return once its write cycle is visible
   task automatic push(input logic [15:0] d, input logic last, output int stalls);
      in_valid = 1'b1; in_data = d; in_last = last;
      #1; stalls = 0;
      while (!in_ready) begin
         @(negedge clk); #1; stalls++;
         if (fifo_wr || fifo_pktend) gap_hits++;
      end
      @(negedge clk); #1;
   endtask

   task automatic idle();
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic expect_word(input string req, input logic [15:0] d, input logic pe, input logic au);
      check({req, " wr"}, fifo_wr, 1'b1);
      check({req, " data"}, fifo_data, d);
      check({req, " pktend"}, fifo_pktend, pe);
      check({req, " auto"}, pkt_auto, au);
   endtask

   task automatic t_reset();
      check("R8 wr", fifo_wr, 1'b0);
      check("R8 pktend", fifo_pktend, 1'b0);
      check("R8 auto", pkt_auto, 1'b0);
      check("R8 ready", in_ready, 1'b1);
      check("R8 addr", fifo_addr, 2'd0);
   endtask

   task automatic t_auto();
      int s;
      for (int i = 0; i < 4; i++) begin
         push(16'h1000 + 16'(i), 1'b0, s);
         expect_word("R2 R1 auto packet", 16'h1000 + 16'(i), 1'b0, i == 3);
      end
      idle(); @(negedge clk); #1;
      check("R1 no extra write", fifo_wr, 1'b0);
   endtask

   task automatic t_short();
      int s;
      push(16'hA001, 1'b0, s); expect_word("R3 short first", 16'hA001, 1'b0, 1'b0);
      push(16'hA002, 1'b1, s); expect_word("R3 short last", 16'hA002, 1'b1, 1'b0);
      for (int i = 0; i < 4; i++) begin
         push(16'hB000 + 16'(i), 1'b0, s);
         expect_word("R3 count restart", 16'hB000 + 16'(i), 1'b0, i == 3);
      end
      idle(); @(negedge clk); #1;
   endtask

   task automatic t_gap();
      int s;
      gap_hits = 0;
      for (int i = 0; i < 4; i++) begin
         push(16'hC000 + 16'(i), 1'b0, s);
         expect_word("R4 auto part", 16'hC000 + 16'(i), 1'b0, i == 3);
      end
      push(16'hC0FF, 1'b1, s);
      check("R4 stall cycles", 32'(s), 32'd1);
      check("R4 gap idle", 32'(gap_hits), 32'd0);
      expect_word("R4 short after gap", 16'hC0FF, 1'b1, 1'b0);
      idle(); @(negedge clk); #1;
      check("R4 pktend dropped", fifo_pktend, 1'b0);
   endtask

   task automatic t_zlp_off();
      int s;
      zlp_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         push(16'hD000 + 16'(i), i == 3, s);
         expect_word("R5 last completes auto", 16'hD000 + 16'(i), 1'b0, i == 3);
      end
      idle();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         check("R5 no zlp when disabled", fifo_pktend, 1'b0);
      end
   endtask

   task automatic t_zlp_on();
      int s;
      zlp_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         push(16'hE000 + 16'(i), i == 3, s);
         expect_word("R5 zlp auto", 16'hE000 + 16'(i), 1'b0, i == 3);
      end
      idle(); #1;
      check("R5 ready low c", in_ready, 1'b0);
      @(negedge clk); #1;
      check("R5 gap pktend", fifo_pktend, 1'b0);
      check("R5 gap wr", fifo_wr, 1'b0);
      check("R5 ready low c+1", in_ready, 1'b0);
      @(negedge clk); #1;
      check("R5 zlp pktend", fifo_pktend, 1'b1);
      check("R5 zlp no wr", fifo_wr, 1'b0);
      check("R5 ready back", in_ready, 1'b1);
      @(negedge clk); #1;
      check("R5 zlp single", fifo_pktend, 1'b0);
      zlp_en = 1'b0;
   endtask

   task automatic t_full();
      fifo_full = 1'b1;
      in_valid = 1'b1; in_data = 16'hBEEF; in_last = 1'b1;
      #1;
      check("R6 ready low", in_ready, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         check("R6 no write", fifo_wr, 1'b0);
         check("R6 still blocked", in_ready, 1'b0);
      end
      fifo_full = 1'b0; #1;
      check("R6 ready after full", in_ready, 1'b1);
      @(negedge clk); #1;
      expect_word("R6 held word", 16'hBEEF, 1'b1, 1'b0);
      idle();
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic t_addr();
      int s;
      ep_sel = 2'd2;
      @(negedge clk); #1;
      check("R7 idle load", fifo_addr, 2'd2);
      push(16'hF001, 1'b0, s);
      check("R7 addr with write", fifo_addr, 2'd2);
      idle();
      ep_sel = 2'd1;
      repeat (2) @(negedge clk);
      #1;
      check("R7 frozen while open", fifo_addr, 2'd2);
      push(16'hF002, 1'b1, s);
      expect_word("R7 close", 16'hF002, 1'b1, 1'b0);
      check("R7 addr at commit", fifo_addr, 2'd2);
      idle();
      repeat (2) @(negedge clk);
      #1;
      check("R7 load after commit", fifo_addr, 2'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_auto();
      t_short();
      t_gap();
      t_zlp_off();
      t_zlp_on();
      t_full();
      t_addr();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule